// File: doc/BRIEF.md
# Wake-up Event Router

The block gathers a vector of event inputs and decides which of them should raise an interrupt request for the interrupt controller and a wake-up request for the core and clock-control logic. Some inputs are internal event or peripheral interrupt lines that are already synchronous to the block clock. The rest are four asynchronous external wake-up pins. Each event is set up on its own. A mode bit picks edge or level detection, a polarity bit picks the active direction, and an enable bit decides whether the event may reach the outputs.

Detected events are held in status bits. In edge mode a status bit stays set until software writes a one to it. In level mode it follows the qualified input. The enabled, pending events are ORed into a wake-up request that comes straight from the status and enable registers, so it holds its level while the clock is stopped. The same term, registered once, forms the interrupt request. Software reaches the configuration and status through a small register port with a two-bit address, write strobe and combinational read data.

Top module: `wake_event_router`

## Requirements
- R1: After reset the mode, polarity, enable and status registers read zero, and `irq_o` and `wake_o` are low.
- R2: Register address 0 holds mode (1 = edge), 1 polarity, 2 enable and 3 status. Bit i of each register belongs to event i. Events 0..N_INT-1 are `int_ev_i`, and event N_INT+j is external pin `ext_wake_i[j]`. Mode, polarity and enable read back the last value written.
- R3: In edge mode a qualified edge sets the event's status bit, and the bit then stays set while the input moves, until it is cleared.
- R4: Polarity 0 selects rising edges (edge mode) or high level (level mode). Polarity 1 selects falling edges or low level.
- R5: In level mode the status bit equals the qualified input level, registered once. Writes to the status register have no effect on level-mode bits.
- R6: A write to address 3 clears every edge-mode status bit where the write data is one. Bits written with zero keep their value.
- R7: When an edge is detected on the same clock edge as a clear of that bit, the bit ends up set.
- R8: An event whose enable bit is zero never drives `irq_o` or `wake_o`, though its status bit is still recorded.
- R9: `wake_o` is high in exactly the cycles where some status bit and its enable bit are both one. It changes in the same cycle as the status or enable register, with no added register.
- R10: `irq_o` equals the value `wake_o` had one cycle earlier.
- R11: An internal event sampled at clock edge n reaches status at edge n. An external pin sampled at edge n reaches status at edge n+2.
- R12: Changing the polarity of an edge-mode event while its input is steady does not set its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_ev_i | input | N_INT | Synchronous internal event lines |
| ext_wake_i | input | N_EXT | Asynchronous external wake-up pins |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | N_INT+N_EXT | Register write data |
| reg_rdata_o | output | N_INT+N_EXT | Read data of the selected register (combinational) |
| irq_o | output | 1 | Registered interrupt request |
| wake_o | output | 1 | Unregistered wake-up request |

## Verification
The bench targets a clear and a fresh edge arriving on the same clock edge. A design that lets the clear win would lose that event. It also flips polarity on an edge-mode event with a steady input, where a detector that compares qualified levels would report a false edge. It checks that writes to the status register leave level-mode bits alone, that external pins take exactly two extra cycles while internal lines take none, and that `irq_o` trails `wake_o` by one cycle. An off-by-one synchronizer or an extra register on `wake_o` would show up as a shifted status read or a wake-up pulse in the wrong cycle. A long random phase then mixes mode, polarity, enable and clear writes with random inputs against a cycle model.

// File: rtl/wer_pkg.sv
package wer_pkg;
  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_POL    = 2'd1,
    SEL_EN     = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/wer_sync.sv
module wer_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wer_regs.sv
module wer_regs
  import wer_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] status_i,
  output logic [N-1:0] mode_o,
  output logic [N-1:0] pol_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] clr_o,
  output logic [N-1:0] rdata_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o <= '0;
      pol_o  <= '0;
      en_o   <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_MODE: mode_o <= wdata_i;
        SEL_POL:  pol_o  <= wdata_i;
        SEL_EN:   en_o   <= wdata_i;
        default:  ;
      endcase
    end
  end

  assign clr_o = (we_i && sel == SEL_STATUS) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_MODE: rdata_o = mode_o;
      SEL_POL:  rdata_o = pol_o;
      SEL_EN:   rdata_o = en_o;
      default:  rdata_o = status_i;
    endcase
  end
endmodule

// File: rtl/wer_detect.sv
module wer_detect #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o
);
  // raw history: a polarity flip alone never looks like an edge
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= ev_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_ev
    logic qual, hit, st_q;
    assign qual = ev_i[i] ^ pol_i[i];
    assign hit  = qual & ~(prev_q[i] ^ pol_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        st_q <= 1'b0;
      else if (mode_i[i]) st_q <= hit | (st_q & ~clr_i[i]);  // detection beats clear
      else                st_q <= qual;
    end

    assign status_o[i] = st_q;
  end
endmodule

// File: rtl/wake_event_router.sv
module wake_event_router
  import wer_pkg::*;
#(
  parameter  int N_INT = 12,
  parameter  int N_EXT = 4,
  localparam int N_EV  = N_INT + N_EXT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_INT-1:0] int_ev_i,
  input  logic [N_EXT-1:0] ext_wake_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [N_EV-1:0]  reg_wdata_i,
  output logic [N_EV-1:0]  reg_rdata_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [N_EXT-1:0] ext_sync;
  logic [N_EV-1:0]  ev_vec, ev_mode, ev_pol, ev_en, ev_clr, ev_status, ev_pend;
  logic             irq_q;

  wer_sync #(.W(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ext_wake_i),
    .q_o    (ext_sync)
  );

  assign ev_vec = {ext_sync, int_ev_i};

  wer_regs #(.N(N_EV)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .status_i (ev_status),
    .mode_o   (ev_mode),
    .pol_o    (ev_pol),
    .en_o     (ev_en),
    .clr_o    (ev_clr),
    .rdata_o  (reg_rdata_o)
  );

  wer_detect #(.N(N_EV)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev_vec),
    .mode_i   (ev_mode),
    .pol_i    (ev_pol),
    .clr_i    (ev_clr),
    .status_o (ev_status)
  );

  assign ev_pend = ev_status & ev_en;
  assign wake_o  = |ev_pend;  // no flop: must hold with the clock stopped

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |ev_pend;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/wer_checker.sv
module wer_checker #(
  parameter  int N_INT = 12,
  parameter  int N_EXT = 4,
  localparam int N_EV  = N_INT + N_EXT
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_INT-1:0] int_ev_i,
  input logic [N_EV-1:0]  mode_i,
  input logic [N_INT-1:0] pol_i,
  input logic [N_EV-1:0]  en_i,
  input logic [N_EV-1:0]  clr_i,
  input logic [N_EV-1:0]  status_i,
  input logic             irq_o,
  input logic             wake_o
);
  logic             past_ok;
  logic [N_EV-1:0]  held;
  logic [N_INT-1:0] lvl_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assign held    = mode_i & status_i & ~clr_i;
  assign lvl_int = ~mode_i[N_INT-1:0];

  p_disabled_silent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !wake_o);

  p_irq_lags_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> (irq_o == $past(wake_o)));

  p_sticky_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held != '0) |=> ((status_i & $past(held)) == $past(held)));

  p_level_tracks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |=> ((status_i[N_INT-1:0] & $past(lvl_int)) ==
                 ($past(int_ev_i ^ pol_i) & $past(lvl_int))));
endmodule

bind wake_event_router wer_checker #(.N_INT(N_INT), .N_EXT(N_EXT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .int_ev_i (int_ev_i),
  .mode_i   (ev_mode),
  .pol_i    (ev_pol[N_INT-1:0]),
  .en_i     (ev_en),
  .clr_i    (ev_clr),
  .status_i (ev_status),
  .irq_o    (irq_o),
  .wake_o   (wake_o)
);

// File: tb/tb_wake_event_router.sv
`timescale 1ns/1ps
module tb_wake_event_router;
  localparam int N_INT = 12;
  localparam int N_EXT = 4;
  localparam int N_EV  = N_INT + N_EXT;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N_INT-1:0] int_ev = '0;
  logic [N_EXT-1:0] ext = '0;
  logic             we = 1'b0;
  logic [1:0]       addr = 2'd0;
  logic [N_EV-1:0]  wdata = '0;
  logic [N_EV-1:0]  rdata;
  logic             irq, wake;

  always #2.5 clk = ~clk;

  wake_event_router #(.N_INT(N_INT), .N_EXT(N_EXT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .int_ev_i(int_ev), .ext_wake_i(ext),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // cycle model built from the requirements
  logic [N_EV-1:0]  m_mode = '0, m_pol = '0, m_en = '0, m_status = '0, m_prev = '0;
  logic [N_EXT-1:0] m_s1 = '0, m_s2 = '0;
  logic             m_irq = 1'b0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, logic [N_EV-1:0] act, logic [N_EV-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N_EV-1:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return m_mode;
      2'd1: return m_pol;
      2'd2: return m_en;
      default: return m_status;
    endcase
  endfunction

  task automatic model_edge();
    logic [N_EV-1:0] ev, qual, hit, clr, nxt;
    ev   = {m_s2, int_ev};
    qual = ev ^ m_pol;
    hit  = qual & ~(m_prev ^ m_pol);
    clr  = (we && addr == 2'd3) ? wdata : '0;
    nxt  = (m_mode & (hit | (m_status & ~clr))) | (~m_mode & qual);
    m_irq  = |(m_status & m_en);
    m_prev = ev;
    m_s2   = m_s1;
    m_s1   = ext;
    if (we) begin
      case (addr)
        2'd0: m_mode = wdata;
        2'd1: m_pol  = wdata;
        2'd2: m_en   = wdata;
        default: ;
      endcase
    end
    m_status = nxt;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    check("R9 wake", N_EV'(wake), N_EV'(|(m_status & m_en)));
    check("R10 irq", N_EV'(irq), N_EV'(m_irq));
    check("R2 rdata", rdata, exp_rd(addr));
    we = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [N_EV-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
  endtask

  task automatic peek(string req, logic [1:0] a, logic [N_EV-1:0] exp);
    addr = a;
    #0.1;
    check(req, rdata, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    peek("R1 mode", 2'd0, '0);
    peek("R1 pol", 2'd1, '0);
    peek("R1 en", 2'd2, '0);
    peek("R1 status", 2'd3, '0);
    check("R1 wake", N_EV'(wake), '0);
    check("R1 irq", N_EV'(irq), '0);

    // R2 readback
    wr(2'd1, 16'hA5C3); peek("R2 pol", 2'd1, 16'hA5C3);
    wr(2'd2, 16'h1234); peek("R2 en", 2'd2, 16'h1234);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'hF0F3); peek("R2 mode", 2'd0, 16'hF0F3);
    step();
    wr(2'd2, 16'hFFFF);
    peek("R1 idle status", 2'd3, 16'h0000);

    // R3 sticky edge on event 0
    int_ev[0] = 1'b1; step(); step();
    peek("R3 set", 2'd3, 16'h0001);
    int_ev[0] = 1'b0; step(); step();
    peek("R3 held", 2'd3, 16'h0001);

    // R6 write-one-to-clear
    wr(2'd3, 16'h0002); peek("R6 zero bits kept", 2'd3, 16'h0001);
    wr(2'd3, 16'h0001); peek("R6 cleared", 2'd3, 16'h0000);
    check("R9 wake drop", N_EV'(wake), '0);
    step();
    check("R10 irq drop", N_EV'(irq), '0);

    // R7 detection wins over clear on event 1
    int_ev[1] = 1'b1; step();
    int_ev[1] = 1'b0; step();
    peek("R7 pre", 2'd3, 16'h0002);
    int_ev[1] = 1'b1; wr(2'd3, 16'h0002);
    peek("R7 set wins", 2'd3, 16'h0002);
    int_ev[1] = 1'b0; wr(2'd3, 16'h0002);
    peek("R6 clear after", 2'd3, 16'h0000);

    // R12 polarity flip on steady input, then R4 falling edge on event 4
    wr(2'd1, 16'h0010); step();
    peek("R12 no edge", 2'd3, 16'h0000);
    int_ev[4] = 1'b1; step();
    peek("R4 rise ignored", 2'd3, 16'h0000);
    int_ev[4] = 1'b0; step();
    peek("R4 fall seen", 2'd3, 16'h0010);
    wr(2'd3, 16'h0010);

    // R5 level mode on events 2 and 3
    int_ev[2] = 1'b1; step();
    peek("R5 level high", 2'd3, 16'h0004);
    wr(2'd3, 16'h0004); peek("R5 clear ignored", 2'd3, 16'h0004);
    int_ev[2] = 1'b0; step();
    peek("R5 level low", 2'd3, 16'h0000);
    wr(2'd1, 16'h0018); step();
    peek("R4 low active", 2'd3, 16'h0008);
    wr(2'd1, 16'h0010); step();
    peek("R5 idle", 2'd3, 16'h0000);

    // R8 disabled event recorded but silent
    wr(2'd2, 16'h0000);
    int_ev[5] = 1'b1; step(); step();
    peek("R8 recorded", 2'd3, 16'h0020);
    check("R8 wake", N_EV'(wake), '0);
    check("R8 irq", N_EV'(irq), '0);
    wr(2'd2, 16'h0020);
    check("R9 wake on enable", N_EV'(wake), 16'h0001);
    step();
    check("R10 irq follows", N_EV'(irq), 16'h0001);
    int_ev[5] = 1'b0; wr(2'd3, 16'h0020);

    // R11 latency
    wr(2'd2, 16'h1040);
    int_ev[6] = 1'b1; step();
    peek("R11 internal same edge", 2'd3, 16'h0040);
    int_ev[6] = 1'b0; wr(2'd3, 16'h0040);
    ext[0] = 1'b1; step();
    peek("R11 ext edge n", 2'd3, 16'h0000);
    step();
    peek("R11 ext edge n+1", 2'd3, 16'h0000);
    step();
    peek("R11 ext edge n+2", 2'd3, 16'h1000);
    check("R9 wake ext", N_EV'(wake), 16'h0001);

    // random phase
    for (int k = 0; k < 2500; k++) begin
      int_ev = N_INT'($urandom);
      ext    = N_EXT'($urandom);
      addr   = 2'($urandom);
      if ($urandom_range(0, 7) == 0) begin
        we = 1'b1;
        wdata = N_EV'($urandom);
      end
      step();
      peek("R3 R5 random status", 2'd3, m_status);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule